// File: doc/BRIEF.md
# Raster Line Interrupt Controller

This block raises a CPU interrupt at a scan line chosen by software. An 8-bit line register sits on the CPU register bus. When it holds zero, the block passes on a legacy periodic interrupt strobe supplied by the video timing logic. When it holds any other value, the legacy strobe is masked. An interrupt is then requested when the end-of-line strobe arrives with the current scan line equal to the register. Software may rewrite the register between line interrupts, so one frame can carry several of them.

Three sound DMA channels can also request interrupts. Each source has its own pending flag, and the interrupt output stays high while any flag is set. On an acknowledge pulse the block takes the highest-priority pending source and clears only that flag. It returns a low vector byte built from a software vector register and a two-bit source code.

Top module: `rli_ctrl`

## Requirements
- R1: After a synchronous reset the line register and the vector register read back 0, `irq` is 0 and `vec_out` is 0.
- R2: A write to address 6800h loads the line register. A write to address 6801h loads the vector register, which reads back with its bits 7..3 as written and bits 2..0 as 0. A read returns data on `bus_rdata` one cycle after `bus_rd`. Writes to any other address change nothing, and reads from them return 0.
- R3: While the line register is 0, a `legacy_tick` pulse sets the line-source pending flag, and `line_end` has no effect.
- R4: While the line register is nonzero, a `line_end` pulse with `line_num` equal to the register sets the line-source pending flag. A non-matching `line_end` has no effect, and neither has `legacy_tick`.
- R5: Rewriting the line register between line ends lets several line interrupts occur within one frame.
- R6: A pulse on `dma_irq[k]` sets the pending flag of DMA channel k (k = 0, 1, 2).
- R7: On `iack` the block picks the pending source in the priority order DMA0, DMA1, DMA2, line. One cycle later `vec_out` holds the vector register's bits 7..3, then a 2-bit source code in bits 2..1 (11 DMA0, 10 DMA1, 01 DMA2, 00 line), then a 0 in bit 0.
- R8: An acknowledge clears only the chosen source's flag. `irq` is high whenever any flag is set and low otherwise, and it updates at the same edge as the flags.
- R9: An `iack` with no flag set gives source code 00 and changes no flag.
- R10: If a source's new request arrives in the same cycle as that source's acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| line_num | input | 8 | Current scan line number from video timing |
| line_end | input | 1 | One-cycle pulse at the end of each scan line |
| legacy_tick | input | 1 | Legacy periodic interrupt strobe |
| dma_irq | input | 3 | Interrupt request pulses, bit k for DMA channel k |
| iack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Low vector byte, valid the cycle after `iack` |

## Verification
The hardest case to reach is a request and an acknowledge of the same source meeting in one cycle, while other sources also hold flags. The acknowledge must then clear exactly one flag, and the new request must not be lost. The random phase drives frequent DMA pulses, line ends over a narrow band of line numbers, and acknowledges all at once, so these collisions happen often. Directed steps also force one collision for each source and run a line-register rewrite inside a frame.

// File: rtl/rli_pkg.sv
package rli_pkg;
  localparam int N_DMA   = 3;
  localparam int N_SRC   = N_DMA + 1;
  localparam int CODE_W  = 2;

  // source code placed in vector bits 2..1
  typedef enum logic [CODE_W-1:0] {
    SRC_LINE = 2'b00,
    SRC_DMA2 = 2'b01,
    SRC_DMA1 = 2'b10,
    SRC_DMA0 = 2'b11
  } src_code_e;

  // DMA channel k maps to code 3-k
  function automatic src_code_e dma_code(input int k);
    return src_code_e'(CODE_W'(N_DMA - k));
  endfunction
endpackage

// File: rtl/rli_regs.sv
module rli_regs #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                CODE_W    = 2,
  parameter logic [ADDR_W-1:0] LINE_ADDR = 16'h6800,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 16'h6801
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        line_reg,
  output logic [DATA_W-CODE_W-2:0] vec_hi,
  output logic [DATA_W-1:0]        rdata
);
  localparam int LOW_W = CODE_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_reg <= '0;
      vec_hi   <= '0;
      rdata    <= '0;
    end else begin
      if (wr && addr == LINE_ADDR) line_reg <= wdata;
      if (wr && addr == VEC_ADDR)  vec_hi   <= wdata[DATA_W-1:LOW_W];
      if (rd) begin
        if (addr == LINE_ADDR)     rdata <= line_reg;
        else if (addr == VEC_ADDR) rdata <= {vec_hi, {LOW_W{1'b0}}};
        else                       rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/rli_src.sv
module rli_src #(
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] line_reg,
  input  logic [LINE_W-1:0] line_num,
  input  logic              line_end,
  input  logic              legacy_tick,
  output logic              line_hit
);
  logic legacy_mode;

  always_comb begin
    legacy_mode = (line_reg == '0);
    if (legacy_mode) line_hit = legacy_tick;
    else             line_hit = line_end && (line_num == line_reg);
  end
endmodule

// File: rtl/rli_arb.sv
module rli_arb
  import rli_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     line_hit,
  input  logic [N_DMA-1:0]         dma_irq,
  input  logic                     iack,
  input  logic [DATA_W-CODE_W-2:0] vec_hi,
  output logic                     irq,
  output logic [DATA_W-1:0]        vec_out
);
  // pend[0] = line source, pend[1+k] = DMA channel k
  logic [N_SRC-1:0] pend, pend_nxt, clr, set;
  src_code_e        sel_code;

  always_comb begin
    sel_code = SRC_LINE;
    clr      = '0;
    if (pend[0]) clr[0] = 1'b1;
    for (int k = N_DMA - 1; k >= 0; k--) begin
      if (pend[k+1]) begin
        sel_code = dma_code(k);
        clr      = '0;
        clr[k+1] = 1'b1;
      end
    end
    set      = {dma_irq, line_hit};
    pend_nxt = (pend & ~(iack ? clr : '0)) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      irq     <= 1'b0;
      vec_out <= '0;
    end else begin
      pend <= pend_nxt;
      irq  <= |pend_nxt;
      if (iack) vec_out <= {vec_hi, sel_code, 1'b0};
    end
  end
endmodule

// File: rtl/rli_ctrl.sv
module rli_ctrl
  import rli_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [15:0]     LINE_ADDR = 16'h6800,
  parameter logic [15:0]     VEC_ADDR  = 16'h6801
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] line_num,
  input  logic              line_end,
  input  logic              legacy_tick,
  input  logic [N_DMA-1:0]  dma_irq,
  input  logic              iack,
  output logic              irq,
  output logic [DATA_W-1:0] vec_out
);
  localparam int HI_W = DATA_W - CODE_W - 1;

  logic [DATA_W-1:0] line_reg;
  logic [HI_W-1:0]   vec_hi;
  logic              line_hit;

  rli_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .LINE_ADDR(ADDR_W'(LINE_ADDR)), .VEC_ADDR(ADDR_W'(VEC_ADDR))
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .line_reg(line_reg), .vec_hi(vec_hi), .rdata(bus_rdata)
  );

  rli_src #(.LINE_W(DATA_W)) u_src (
    .line_reg(line_reg), .line_num(line_num), .line_end(line_end),
    .legacy_tick(legacy_tick), .line_hit(line_hit)
  );

  rli_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst(rst), .line_hit(line_hit), .dma_irq(dma_irq),
    .iack(iack), .vec_hi(vec_hi), .irq(irq), .vec_out(vec_out)
  );
endmodule

// File: rtl/rli_ctrl_chk.sv
module rli_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int N_DMA  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] line_reg,
  input logic [DATA_W-1:0] line_num,
  input logic              line_end,
  input logic              legacy_tick,
  input logic [N_DMA-1:0]  dma_irq,
  input logic              iack,
  input logic              irq,
  input logic [DATA_W-1:0] vec_out
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && vec_out == '0));

  // R3
  a_r3_legacy_fires: assert property (@(posedge clk) disable iff (rst)
    (line_reg == '0 && legacy_tick) |=> irq);

  // R4
  a_r4_line_match: assert property (@(posedge clk) disable iff (rst)
    (line_reg != '0 && line_end && line_num == line_reg) |=> irq);

  // R6
  a_r6_dma_fires: assert property (@(posedge clk) disable iff (rst)
    (|dma_irq) |=> irq);

  // R8
  a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !iack) |=> irq);

  // R9
  a_r9_empty_ack: assert property (@(posedge clk) disable iff (rst)
    (iack && !irq) |=> (vec_out[2:1] == 2'b00));
endmodule

bind rli_ctrl rli_ctrl_chk #(.DATA_W(DATA_W), .N_DMA(rli_pkg::N_DMA)) u_chk (
  .clk(clk), .rst(rst), .line_reg(line_reg), .line_num(line_num),
  .line_end(line_end), .legacy_tick(legacy_tick), .dma_irq(dma_irq),
  .iack(iack), .irq(irq), .vec_out(vec_out)
);

// File: tb/rli_ctrl_test.sv
`timescale 1ns/1ps
module rli_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  line_num;
  logic        line_end, legacy_tick;
  logic [2:0]  dma_irq;
  logic        iack, irq;
  logic [7:0]  vec_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model: m_pend[0] line, m_pend[1+k] DMA k
  logic [7:0] m_line, m_vec;
  logic [3:0] m_pend;

  always #10 clk = ~clk;

  rli_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_num(line_num),
    .line_end(line_end), .legacy_tick(legacy_tick), .dma_irq(dma_irq),
    .iack(iack), .irq(irq), .vec_out(vec_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected vector code and cleared flag for an acknowledge
  function automatic logic [2:0] ack_pick(input logic [3:0] p);
    if (p[1])      return {2'b11, 1'b1};
    else if (p[2]) return {2'b10, 1'b1};
    else if (p[3]) return {2'b01, 1'b1};
    else           return {2'b00, p[0]};
  endfunction

  function automatic logic [3:0] ack_mask(input logic [3:0] p);
    if (p[1])      return 4'b0010;
    else if (p[2]) return 4'b0100;
    else if (p[3]) return 4'b1000;
    else           return {3'b000, p[0]};
  endfunction

  // one bus/event cycle; called just after a falling edge
  task automatic step(input string req,
                      input logic wr, input logic rd, input logic [15:0] a,
                      input logic [7:0] wd, input logic [7:0] ln, input logic le,
                      input logic lt, input logic [2:0] d, input logic ak);
    logic       hit;
    logic [2:0] pk;
    logic [7:0] e_vec, e_rd;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    line_num = ln; line_end = le; legacy_tick = lt; dma_irq = d; iack = ak;
    hit   = (m_line == 8'd0) ? lt : (le && ln == m_line);
    pk    = ack_pick(m_pend);
    e_vec = {m_vec[7:3], pk[2:1], 1'b0};
    e_rd  = (a == 16'h6800) ? m_line : (a == 16'h6801) ? {m_vec[7:3], 3'b000} : 8'h00;
    if (ak) m_pend = m_pend & ~ack_mask(m_pend);
    m_pend = m_pend | {d, hit};
    if (wr && a == 16'h6800) m_line = wd;
    if (wr && a == 16'h6801) m_vec  = {wd[7:3], 3'b000};
    @(posedge clk); #3;
    check(req, {7'd0, irq}, {7'd0, |m_pend});
    if (ak) check(req, vec_out, e_vec);
    if (rd) check(req, bus_rdata, e_rd);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; line_end = 0; legacy_tick = 0; dma_irq = 0; iack = 0;
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 16'h0, 8'h0, 8'h0, 0, 0, 3'b0, 0);
  endtask

  task automatic wreg(input string req, input logic [15:0] a, input logic [7:0] d);
    step(req, 1, 0, a, d, 8'h0, 0, 0, 3'b0, 0);
  endtask

  task automatic rreg(input string req, input logic [15:0] a);
    step(req, 0, 1, a, 8'h0, 8'h0, 0, 0, 3'b0, 0);
  endtask

  task automatic ack(input string req);
    step(req, 0, 0, 16'h0, 8'h0, 8'h0, 0, 0, 3'b0, 1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    line_num = 0; line_end = 0; legacy_tick = 0; dma_irq = 0; iack = 0;
    m_line = 0; m_vec = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1", {7'd0, irq}, 8'd0);
    check("R1", vec_out, 8'd0);
    rreg("R1", 16'h6800);
    rreg("R1", 16'h6801);

    // R2 register access
    wreg("R2", 16'h6801, 8'hA7);
    rreg("R2", 16'h6801);
    wreg("R2", 16'h6802, 8'h55);
    rreg("R2", 16'h6802);
    rreg("R2", 16'h6800);

    // R3 legacy mode: line_end ignored, tick fires
    step("R3", 0, 0, 0, 0, 8'd0, 1, 0, 3'b0, 0);
    step("R3", 0, 0, 0, 0, 8'd0, 0, 1, 3'b0, 0);
    ack("R3");
    idle("R3");

    // R4 line mode
    wreg("R4", 16'h6800, 8'd20);
    step("R4", 0, 0, 0, 0, 8'd19, 1, 1, 3'b0, 0);
    step("R4", 0, 0, 0, 0, 8'd20, 0, 0, 3'b0, 0);
    step("R4", 0, 0, 0, 0, 8'd20, 1, 0, 3'b0, 0);
    ack("R4");

    // R5 two line interrupts in one frame via rewrite
    step("R5", 0, 0, 0, 0, 8'd20, 1, 0, 3'b0, 0);
    ack("R5");
    wreg("R5", 16'h6800, 8'd40);
    step("R5", 0, 0, 0, 0, 8'd40, 1, 0, 3'b0, 0);
    ack("R5");

    // R6 / R7 / R8 priority and selective clear
    step("R6", 0, 0, 0, 0, 8'd40, 1, 0, 3'b111, 0);
    ack("R7"); ack("R7"); ack("R8"); ack("R8");
    // R9 empty acknowledge
    ack("R9");
    idle("R9");

    // R10 collision per source
    for (int k = 0; k < 3; k++) begin
      step("R10", 0, 0, 0, 0, 8'd0, 0, 0, 3'(1 << k), 0);
      step("R10", 0, 0, 0, 0, 8'd0, 0, 0, 3'(1 << k), 1);
      ack("R10");
    end
    step("R10", 0, 0, 0, 0, 8'd40, 1, 0, 3'b0, 0);
    step("R10", 0, 0, 0, 0, 8'd40, 1, 0, 3'b0, 1);
    ack("R10");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r = 4'($urandom_range(0, 15));
      if (r == 0)
        wreg("R2", 16'h6800, 8'($urandom_range(0, 5)));
      else if (r == 1)
        wreg("R2", 16'h6801, 8'($urandom));
      else if (r == 2)
        rreg("R2", 16'h6800 + 16'($urandom_range(0, 2)));
      else
        step("R8", 0, 0, 0, 0, 8'($urandom_range(0, 5)),
             1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
             3'($urandom_range(0, 7) & $urandom_range(0, 7)),
             ($urandom_range(0, 2) == 0));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule